// File: doc/BRIEF.md
# Prescaled 16-Bit Timer with Phase-Sampled Synchronizer

This block is a 16-bit up-counter that advances either once per instruction cycle or on edges of an external timer pin. The oscillator clock drives the whole block. A free-running two-bit phase counter splits each instruction cycle into four oscillator-period phases, Q1 to Q4. The chosen event stream passes through a programmable prescaler with ratios from 1:1 up to 1:256. On the external path, the prescaler output is not trusted directly. It is sampled on the Q2 and Q4 phases, and a low-to-high change between two samples makes one increment. As a result, a prescaler pulse that rises and falls between two sample points is lost.

When the counter rolls from 0xFFFF to 0x0000 it raises an overflow flag. The interrupt request is the flag gated by an enable bit. An acknowledge pulse from the interrupt controller clears the flag. Software writes a control word, can load the count at any time, and reads the count back.

Top module: `tmr16_presync`

## Requirements
- R1: After reset the count is 0x0000, the flag, enable and request outputs are 0, and the control word reads 0x00 (external source, falling edge, prescale code 0).
- R2: A control write stores the word, and it reads back unchanged on the next cycle. Bits [3:0] hold the prescale code, bit 4 selects the rising edge (1) or the falling edge (0), bit 5 selects the internal source (1) or the pin (0), and bit 6 is the interrupt enable. The enable output follows bit 6.
- R3: With the internal source, the count advances by exactly one every 4·2^e oscillator cycles, where e is the prescale code for codes 0..7. Outside a load, the count never changes by anything other than +1.
- R4: Prescale codes 8 to 15 all give a 1:256 ratio.
- R5: With the pin source and the rising edge selected, each rising pin edge of at least two oscillator periods in each level gives one increment at code 0.
- R6: With the pin source and the falling edge selected, each falling pin edge gives one increment, and rising edges give none.
- R7: With the pin source, code e gives one increment per 2^e selected edges, counted from the last count load. Code 3 turns 20 edges into 2 increments, and code 1 turns 9 edges into 4.
- R8: A pin pulse whose synchronized high time is one oscillator period produces an increment only when a Q2 or Q4 sample falls inside it. Four such pulses spaced 21 cycles apart give exactly 2 increments.
- R9: At code 0 with the pin source, the count changes between 3 and 5 oscillator periods after the active pin edge.
- R10: An increment from 0xFFFF wraps the count to 0x0000 and sets the flag. A load never sets the flag.
- R11: The interrupt request is high exactly when the flag and the enable bit are both 1.
- R12: An acknowledge pulse clears the flag unless a wrap happens in the same cycle.
- R13: A count load takes priority over an increment in the same cycle. While loads repeat every cycle, the count holds the loaded value. A load also clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| t_pin | input | 1 | External timer pin, asynchronous |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | Control word to write |
| ctl_rdata | output | 7 | Current control word |
| cnt_we | input | 1 | Count load strobe |
| cnt_wdata | input | 16 | Count load value |
| cnt_rdata | output | 16 | Current count |
| ovf_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| ovf_flag | output | 1 | Overflow flag |
| ovf_en | output | 1 | Interrupt enable bit |
| ovf_irq | output | 1 | Masked interrupt request |

## Verification
A phase counter or sampler in the wrong state shows up at the count port as bad increment timing. The internal rate drifts from one step per 4·2^e cycles, the edge-to-count delay leaves the 3-to-5 period window, or the count of one-cycle pulses differs from 2. Each of these is visible inside a single test window of a few dozen cycles. A stale prescaler bit changes the first increment after a load, so externally counted totals come out one too high or too low once the pin goes idle. Flag faults appear on the cycle right after the wrap or the acknowledge.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   localparam int CODE_W = 4;

   typedef enum logic [1:0] {
      PH_Q1 = 2'd0,
      PH_Q2 = 2'd1,
      PH_Q3 = 2'd2,
      PH_Q4 = 2'd3
   } phase_e;

   typedef struct packed {
      logic              irq_en;
      logic              src_int;
      logic              rise;
      logic [CODE_W-1:0] ps_code;
   } tmr_ctl_t;
endpackage

// File: rtl/tmr_phase_gen.sv
`timescale 1ns/1ps
module tmr_phase_gen
   import tmr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   output logic smp_stb,
   output logic cyc_stb
);
   phase_e ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= PH_Q1;
      else        ph <= phase_e'(ph + 2'd1);
   end

   // sampling points fall on the second and fourth phase
   assign smp_stb = (ph == PH_Q2) || (ph == PH_Q4);
   assign cyc_stb = (ph == PH_Q4);
endmodule

// File: rtl/tmr_src_front.sv
`timescale 1ns/1ps
module tmr_src_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise,
   output logic lvl,
   output logic tick
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
   end

   // polarity-corrected level: active edge becomes a rising edge
   assign lvl = rise ? sync_q[SYNC_STAGES-1] : ~sync_q[SYNC_STAGES-1];

   // reset value matches the level seen under the reset control word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b1;
      else        lvl_d <= lvl;
   end

   assign tick = lvl & ~lvl_d;
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
   import tmr_pkg::*;
#(
   parameter int STAGES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  logic [CODE_W-1:0] code,
   input  logic              lvl,
   output logic              psout,
   output logic              wrap,
   output logic              bypass
);
   generate
      if (STAGES == 0) begin : g_none
         assign psout  = lvl;
         assign wrap   = adv;
         assign bypass = 1'b1;
      end else begin : g_div
         localparam int EW = $clog2(STAGES + 1);
         logic [STAGES-1:0] pcnt;
         logic [EW-1:0]     e;
         logic              low_ones;
         logic              pbit;

         // codes at or above the stage count saturate to the full chain
         always_comb begin
            if (int'(code) >= STAGES) e = EW'(STAGES);
            else                      e = EW'(code);
         end

         always_comb begin
            low_ones = 1'b1;
            pbit     = 1'b0;
            for (int i = 0; i < STAGES; i++) begin
               if (i < int'(e))      low_ones = low_ones & pcnt[i];
               if (i == int'(e) - 1) pbit     = ~pcnt[i];
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pcnt <= '0;
            else if (clr) pcnt <= '0;
            else if (adv) pcnt <= pcnt + 1'b1;
         end

         assign bypass = (e == '0);
         // inverted tap rises when the low e bits roll to zero
         assign psout  = bypass ? lvl : pbit;
         assign wrap   = adv & low_ones;
      end
   endgenerate
endmodule

// File: rtl/tmr_q_sampler.sv
`timescale 1ns/1ps
module tmr_q_sampler (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic prime,
   input  logic prime_val,
   input  logic psout,
   output logic pls
);
   logic samp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp <= 1'b1;
         pls  <= 1'b0;
      end else if (prime) begin
         samp <= prime_val;
         pls  <= 1'b0;
      end else begin
         pls <= 1'b0;
         if (stb) begin
            samp <= psout;
            pls  <= psout & ~samp;
         end
      end
   end
endmodule

// File: rtl/tmr16_presync.sv
`timescale 1ns/1ps
module tmr16_presync
   import tmr_pkg::*;
#(
   parameter int  CNT_W       = 16,
   parameter int  PS_STAGES   = 8,
   parameter int  SYNC_STAGES = 2,
   localparam int CTL_W       = CODE_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             t_pin,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_rdata,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   output logic [CNT_W-1:0] cnt_rdata,
   input  logic             ovf_ack,
   output logic             ovf_flag,
   output logic             ovf_en,
   output logic             ovf_irq
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (PS_STAGES < 0 || PS_STAGES > (1 << CODE_W) - 1) begin : g_bad_ps
         $error("PS_STAGES must fit the prescale code range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   tmr_ctl_t         ctl_q;
   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;
   logic             smp_stb, cyc_stb;
   logic             lvl, tick;
   logic             adv, psout, wrap, bypass;
   logic             pls, inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_we) ctl_q <= tmr_ctl_t'(ctl_wdata);
   end

   tmr_phase_gen u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_stb (smp_stb),
      .cyc_stb (cyc_stb)
   );

   tmr_src_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (t_pin),
      .rise  (ctl_q.rise),
      .lvl   (lvl),
      .tick  (tick)
   );

   assign adv = ctl_q.src_int ? cyc_stb : tick;

   tmr_prescaler #(.STAGES(PS_STAGES)) u_ps (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cnt_we),
      .adv    (adv),
      .code   (ctl_q.ps_code),
      .lvl    (lvl),
      .psout  (psout),
      .wrap   (wrap),
      .bypass (bypass)
   );

   tmr_q_sampler u_samp (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb       (smp_stb),
      .prime     (cnt_we),
      .prime_val (bypass ? lvl : 1'b1),
      .psout     (psout),
      .pls       (pls)
   );

   // internal source is already phase aligned; the pin path goes through the sampler
   assign inc = ctl_q.src_int ? wrap : pls;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_we) cnt_q <= cnt_wdata;
      else if (inc)    cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               flag_q <= 1'b0;
      else if (inc && !cnt_we && cnt_q == '1)   flag_q <= 1'b1;
      else if (ovf_ack)                         flag_q <= 1'b0;
   end

   assign ctl_rdata = ctl_q;
   assign cnt_rdata = cnt_q;
   assign ovf_flag  = flag_q;
   assign ovf_en    = ctl_q.irq_en;
   assign ovf_irq   = flag_q & ctl_q.irq_en;
endmodule

// File: rtl/tmr16_presync_chk.sv
`timescale 1ns/1ps
module tmr16_presync_chk #(
   parameter int CNT_W = 16,
   parameter int CTL_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_we,
   input logic [CTL_W-1:0] ctl_wdata,
   input logic [CTL_W-1:0] ctl_rdata,
   input logic             cnt_we,
   input logic [CNT_W-1:0] cnt_wdata,
   input logic [CNT_W-1:0] cnt_rdata,
   input logic             ovf_ack,
   input logic             ovf_flag,
   input logic             ovf_en,
   input logic             ovf_irq
);
   assert_ctl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_we) |-> ctl_rdata == $past(ctl_wdata));

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cnt_we) && cnt_rdata != $past(cnt_rdata))
      |-> cnt_rdata == CNT_W'($past(cnt_rdata) + 1'b1));

   assert_min_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cnt_we) && !$past(cnt_we, 2) && $past(cnt_rdata) != $past(cnt_rdata, 2))
      |-> cnt_rdata == $past(cnt_rdata));

   assert_flag_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> ($past(cnt_rdata) == '1 && cnt_rdata == '0));

   assert_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_en |-> !ovf_irq);

   assert_ack_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ovf_ack) && $past(cnt_rdata) != '1) |-> !ovf_flag);

   assert_write_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cnt_we) |-> cnt_rdata == $past(cnt_wdata));
endmodule

bind tmr16_presync tmr16_presync_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_we    (ctl_we),
   .ctl_wdata (ctl_wdata),
   .ctl_rdata (ctl_rdata),
   .cnt_we    (cnt_we),
   .cnt_wdata (cnt_wdata),
   .cnt_rdata (cnt_rdata),
   .ovf_ack   (ovf_ack),
   .ovf_flag  (ovf_flag),
   .ovf_en    (ovf_en),
   .ovf_irq   (ovf_irq)
);

// File: tb/sim_tmr16_presync.sv
`timescale 1ns/1ps
module sim_tmr16_presync;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        t_pin = 1'b0;
   logic        ctl_we = 1'b0;
   logic [6:0]  ctl_wdata = '0;
   logic [6:0]  ctl_rdata;
   logic        cnt_we = 1'b0;
   logic [15:0] cnt_wdata = '0;
   logic [15:0] cnt_rdata;
   logic        ovf_ack = 1'b0;
   logic        ovf_flag, ovf_en, ovf_irq;

   always #5 clk = ~clk;

   tmr16_presync u0 (
      .clk(clk), .rst_n(rst_n), .t_pin(t_pin),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
      .ovf_ack(ovf_ack), .ovf_flag(ovf_flag), .ovf_en(ovf_en), .ovf_irq(ovf_irq)
   );

   typedef struct {
      string req;
      int    sel;
      int    exp;
   } item_t;

   item_t sbq[$];
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   function automatic int pick(int sel);
      case (sel)
         0: return int'(cnt_rdata);
         1: return int'(ovf_flag);
         2: return int'(ovf_irq);
         3: return int'(ctl_rdata);
         default: return int'(ovf_en);
      endcase
   endfunction

   // monitor: compares queued expectations away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         while (sbq.size() > 0) begin
            item_t it;
            int    act;
            it  = sbq.pop_front();
            act = pick(it.sel);
            n_chk++;
            if (act != it.exp) begin
               n_fail++;
               $display("FAIL %s: sel %0d got 0x%0h expected 0x%0h", it.req, it.sel, act, it.exp);
            end
         end
      end
   end

   // queue an item checked at the negedge after the next posedge
   task automatic expect_val(string r, int sel, int e);
      @(posedge clk);
      #1;
      sbq.push_back('{r, sel, e});
   endtask

   task automatic set_ctl(logic [6:0] v);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic wr_cnt(logic [15:0] v);
      @(negedge clk);
      cnt_we = 1'b1; cnt_wdata = v;
      @(negedge clk);
      cnt_we = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
   endtask

   // slow edges at a period unrelated to the clock
   task automatic ext_edges(int n, logic rest);
      repeat (n) begin
         #47 t_pin = ~rest;
         #53 t_pin = rest;
      end
      idle(40);
   endtask

   // exact window: n_cyc edges contain exactly k increments
   task automatic rate_window(string r, int n_cyc, int k);
      int a;
      @(posedge clk);
      #1;
      a = int'(cnt_rdata);
      repeat (n_cyc) @(posedge clk);
      #1;
      sbq.push_back('{r, 0, (a + k) & 16'hFFFF});
   endtask

   task automatic finish_run();
      idle(3);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int b;
      idle(5);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      expect_val("R1", 0, 0);
      expect_val("R1", 1, 0);
      expect_val("R1", 2, 0);
      expect_val("R1", 3, 0);
      expect_val("R1", 4, 0);

      // R2 control layout and readback
      set_ctl(7'h65);
      expect_val("R2", 3, 'h65);
      expect_val("R2", 4, 1);

      // R3 internal source, codes 0 and 2
      set_ctl(7'h20);
      wr_cnt(16'h0100);
      rate_window("R3", 40, 10);
      set_ctl(7'h22);
      rate_window("R3", 80, 5);

      // R4 saturated codes
      set_ctl(7'h2B);
      rate_window("R4", 2048, 2);
      set_ctl(7'h28);
      rate_window("R4", 1024, 1);

      // R13 repeated loads hold the value
      set_ctl(7'h20);
      @(negedge clk);
      cnt_we = 1'b1; cnt_wdata = 16'h1234;
      repeat (12) expect_val("R13", 0, 'h1234);
      @(negedge clk);
      cnt_we = 1'b0;

      // R5 external rising
      t_pin = 1'b0;
      set_ctl(7'h10);
      idle(10);
      wr_cnt(16'h0000);
      ext_edges(7, 1'b0);
      expect_val("R5", 0, 7);

      // R6 external falling
      t_pin = 1'b1;
      set_ctl(7'h00);
      idle(10);
      wr_cnt(16'h0050);
      ext_edges(5, 1'b1);
      expect_val("R6", 0, 'h55);

      // R7 external prescale
      t_pin = 1'b0;
      set_ctl(7'h13);
      idle(10);
      wr_cnt(16'h0000);
      ext_edges(20, 1'b0);
      expect_val("R7", 0, 2);
      set_ctl(7'h11);
      idle(10);
      wr_cnt(16'h0000);
      ext_edges(9, 1'b0);
      expect_val("R7", 0, 4);

      // R8 one-cycle pulses at alternating sample alignment
      set_ctl(7'h10);
      idle(10);
      wr_cnt(16'h0000);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         t_pin = 1'b1;
         @(negedge clk);
         t_pin = 1'b0;
         repeat (19) @(negedge clk);
      end
      idle(20);
      expect_val("R8", 0, 2);

      // R9 latency window
      wr_cnt(16'h0200);
      idle(10);
      @(posedge clk);
      #1;
      b = int'(cnt_rdata);
      @(negedge clk);
      t_pin = 1'b1;
      repeat (2) @(posedge clk);
      expect_val("R9", 0, b);
      repeat (1) @(posedge clk);
      expect_val("R9", 0, b + 1);
      t_pin = 1'b0;
      idle(20);

      // R10..R12 wrap, flag, mask, acknowledge
      wr_cnt(16'hFFFE);
      ext_edges(1, 1'b0);
      expect_val("R10", 0, 'hFFFF);
      expect_val("R10", 1, 0);
      ext_edges(1, 1'b0);
      expect_val("R10", 0, 0);
      expect_val("R10", 1, 1);
      expect_val("R11", 2, 0);
      set_ctl(7'h50);
      expect_val("R11", 2, 1);
      expect_val("R11", 4, 1);
      @(negedge clk);
      ovf_ack = 1'b1;
      @(negedge clk);
      ovf_ack = 1'b0;
      expect_val("R12", 1, 0);
      expect_val("R11", 2, 0);

      done = 1'b1;
      finish_run();
   end
endmodule